// File: doc/BRIEF.md
# Wired Interrupt Source Gateway Array

This block keeps the state of a small, parameterised set of wired interrupt sources. Each source has a configuration word, a pending bit, an enable bit and a captured copy of its input wire. Identifiers run from 1 to `NUM_SRC-1`; identifier 0 does not exist. On every clock edge each source samples its input. Depending on the configured sense mode (rising edge, falling edge, level high or level low), it may set its pending bit.

Software reaches the state through a word-aligned register port. Writes land on the clock edge and reads are combinational. Pending and enable bits can be set or cleared either as 32-bit bitmap words or by writing a source number. The enabled-and-pending vector goes to a downstream delivery stage. That stage returns a per-source strobe that clears the pending bit once the interrupt has been taken.

The register port uses a 12-bit word address split into a region in bits 11:8 and an offset in bits 7:0. The regions are:
- 0: source configuration, with the offset equal to the source identifier.
- 1: set-pending bitmap, with the offset equal to the word index.
- 2: clear-pending bitmap.
- 3: set-enable bitmap.
- 4: clear-enable bitmap.
- 5: by-number registers. Offset 0 sets pending, 1 clears pending, 2 sets enable, 3 clears enable, and 4 sets pending from a byte-swapped number.

Top module: `irq_gateway_array`

## Requirements
- R1: A configuration word with bit 10 clear keeps only its low 3 bits as the sense mode: 0 off, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low. All other bits read back as zero.
- R2: A configuration word with bit 10 set (delegated) keeps bits 10:0, where bits 9:0 are a child index. When `HAS_CHILD` is 0, such a write stores zero instead.
- R3: A configuration write whose stored value is delegated or all zero clears the pending and enable bits of that source on the same edge.
- R4: In rising-edge mode, pending sets when the input is high and the previously sampled input was low. A steady high input does not set it again after it has been cleared. Falling-edge mode is the mirror case.
- R5: In level-high mode, pending sets on any edge where the input is high. Level-low mode does the same while the input is low.
- R6: The raw input of every source is captured on each edge in every mode. It reads back through the clear-pending bitmap region.
- R7: On a source that is delegated or in off mode, software set or clear of pending or enable has no effect.
- R8: On level-mode sources, software set and clear of pending are both ignored while `msi_mode_i` is 0. While `msi_mode_i` is 1, set is honoured and clear is ignored.
- R9: Bitmap bit 0 of word 0, bitmap bits for identifiers at or above `NUM_SRC`, and by-number writes of 0 or of numbers at or above `NUM_SRC` read as zero and change nothing.
- R10: The set-pending bitmap reads pending bits and the set-enable bitmap reads enable bits. The clear-enable bitmap and all by-number registers read zero, as do configuration reads for identifiers that do not exist.
- R11: A write to by-number offset 4 byte-swaps the data before using it as a source number.
- R12: `enpend_o` is the AND of pending and enable per source. A `dlv_clr_i` strobe clears pending on that edge, taking priority over a hardware set in the same cycle.
- R13: After reset, every configuration, pending, enable and captured-input bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msi_mode_i | input | 1 | 1 selects message delivery rules for software writes to level sources |
| irq_i | input | NUM_SRC | Wired interrupt inputs, bit i is source i |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| enpend_o | output | NUM_SRC | Enabled-and-pending vector to the delivery stage |
| dlv_clr_i | input | NUM_SRC | Per-source pending clear strobe from the delivery stage |

## Verification
The main bench instance is built with `NUM_SRC` = 20 and children present. That leaves bits 20 to 31 of bitmap word 0 as non-existent identifiers, so the masking of out-of-range bits and by-number values can be checked in a single word. A second instance, with `NUM_SRC` = 8 and no children, makes the rule that a delegated write stores zero observable. On the main instance, one source is swept through every sense mode plus delegation, under both delivery settings, applying software set-pending, clear-pending and set-enable. Expected results are derived arithmetically from whether the mode is frozen or level.

// File: rtl/irqgw_pkg.sv
package irqgw_pkg;
  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } sense_e;

  localparam int CFG_W   = 11;
  localparam int DLG_BIT = 10;

  localparam logic [3:0] RG_CFG   = 4'd0;
  localparam logic [3:0] RG_SETIP = 4'd1;
  localparam logic [3:0] RG_CLRIP = 4'd2;
  localparam logic [3:0] RG_SETIE = 4'd3;
  localparam logic [3:0] RG_CLRIE = 4'd4;
  localparam logic [3:0] RG_NUM   = 4'd5;

  localparam logic [7:0] NUM_SETIP    = 8'd0;
  localparam logic [7:0] NUM_CLRIP    = 8'd1;
  localparam logic [7:0] NUM_SETIE    = 8'd2;
  localparam logic [7:0] NUM_CLRIE    = 8'd3;
  localparam logic [7:0] NUM_SETIP_BE = 8'd4;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/irqgw_wdec.sv
module irqgw_wdec
  import irqgw_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter bit HAS_CHILD = 1'b1
) (
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [NUM_SRC-1:0] cfg_we_o,
  output logic [CFG_W-1:0]  cfg_wdata_o,
  output logic [NUM_SRC-1:0] set_ip_o,
  output logic [NUM_SRC-1:0] clr_ip_o,
  output logic [NUM_SRC-1:0] set_ie_o,
  output logic [NUM_SRC-1:0] clr_ie_o
);
  logic [3:0]  region;
  logic [7:0]  ofs;
  logic [31:0] num_val;

  assign region  = addr_i[11:8];
  assign ofs     = addr_i[7:0];
  assign num_val = (ofs == NUM_SETIP_BE) ? bswap32(wdata_i) : wdata_i;

  always_comb begin
    if (wdata_i[DLG_BIT]) cfg_wdata_o = HAS_CHILD ? wdata_i[CFG_W-1:0] : '0;
    else                  cfg_wdata_o = {8'b0, wdata_i[2:0]};
  end

  assign cfg_we_o[0] = 1'b0;
  assign set_ip_o[0] = 1'b0;
  assign clr_ip_o[0] = 1'b0;
  assign set_ie_o[0] = 1'b0;
  assign clr_ie_o[0] = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    localparam logic [7:0] WORD_IDX = 8'(i / 32);
    localparam int         BIT_IDX  = i % 32;
    logic bm_hit, num_hit;
    assign bm_hit  = (ofs == WORD_IDX) && wdata_i[BIT_IDX];
    assign num_hit = (region == RG_NUM) && (num_val == 32'(i));
    assign cfg_we_o[i] = we_i && (region == RG_CFG) && (ofs == 8'(i));
    assign set_ip_o[i] = we_i && (((region == RG_SETIP) && bm_hit) ||
                         (num_hit && ((ofs == NUM_SETIP) || (ofs == NUM_SETIP_BE))));
    assign clr_ip_o[i] = we_i && (((region == RG_CLRIP) && bm_hit) ||
                         (num_hit && (ofs == NUM_CLRIP)));
    assign set_ie_o[i] = we_i && (((region == RG_SETIE) && bm_hit) ||
                         (num_hit && (ofs == NUM_SETIE)));
    assign clr_ie_o[i] = we_i && (((region == RG_CLRIE) && bm_hit) ||
                         (num_hit && (ofs == NUM_CLRIE)));
  end

  always_comb begin
    if (we_i && (region == RG_NUM))
      AST_NUM_ONEHOT: assert ($onehot0(set_ip_o | clr_ip_o | set_ie_o | clr_ie_o)); // R9
  end
endmodule

// File: rtl/irqgw_src_cell.sv
module irqgw_src_cell
  import irqgw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msi_mode_i,
  input  logic             irq_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             set_ip_i,
  input  logic             clr_ip_i,
  input  logic             set_ie_i,
  input  logic             clr_ie_i,
  input  logic             dlv_clr_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             ip_o,
  output logic             ie_o,
  output logic             in_o
);
  logic [CFG_W-1:0] cfg_q;
  logic ip_q, ie_q, in_q, ip_d, ie_d;
  logic [2:0] mode;
  logic dlg, frozen, level, hw_set, sw_set_ok, sw_clr_ok, cfg_kill;

  assign mode   = cfg_q[2:0];
  assign dlg    = cfg_q[DLG_BIT];
  assign frozen = dlg || (mode == SM_OFF);
  assign level  = !dlg && (mode[2:1] == 2'b11);

  always_comb begin
    hw_set = 1'b0;
    if (!dlg) begin
      case (mode)
        SM_RISE: hw_set = irq_i && !in_q;
        SM_FALL: hw_set = !irq_i && in_q;
        SM_HIGH: hw_set = irq_i;
        SM_LOW:  hw_set = !irq_i;
        default: hw_set = 1'b0;
      endcase
    end
  end

  assign sw_set_ok = set_ip_i && !frozen && (!level || msi_mode_i);
  assign sw_clr_ok = clr_ip_i && !frozen && !level;
  assign cfg_kill  = cfg_we_i && (cfg_wdata_i[DLG_BIT] || (cfg_wdata_i == '0));

  always_comb begin
    ip_d = ip_q;
    if (hw_set || sw_set_ok) ip_d = 1'b1;
    if (sw_clr_ok)           ip_d = 1'b0;
    if (dlv_clr_i)           ip_d = 1'b0; // delivery clear beats a same-cycle set
    if (cfg_kill)            ip_d = 1'b0;
    ie_d = ie_q;
    if (set_ie_i && !frozen) ie_d = 1'b1;
    if (clr_ie_i && !frozen) ie_d = 1'b0;
    if (cfg_kill)            ie_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ip_q  <= 1'b0;
      ie_q  <= 1'b0;
      in_q  <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
      ip_q <= ip_d;
      ie_q <= ie_d;
      in_q <= irq_i;
    end
  end

  assign cfg_o = cfg_q;
  assign ip_o  = ip_q;
  assign ie_o  = ie_q;
  assign in_o  = in_q;

  AST_DLV_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_clr_i |=> !ip_q); // R12
  AST_FROZEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |-> (!ip_q && !ie_q)); // R7
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level && ip_q && !dlv_clr_i && !cfg_we_i) |=> ip_q); // R8
  AST_EDGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dlg && (mode == SM_RISE) && !ip_q && !set_ip_i && !cfg_we_i &&
     !(irq_i && !in_q)) |=> !ip_q); // R4
endmodule

// File: rtl/irq_gateway_array.sv
module irq_gateway_array
  import irqgw_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter bit HAS_CHILD = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msi_mode_i,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               we_i,
  input  logic [11:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_SRC-1:0] enpend_o,
  input  logic [NUM_SRC-1:0] dlv_clr_i
);
  localparam int NWORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W  = NWORDS * 32;

  logic [NUM_SRC-1:0] cfg_we, set_ip, clr_ip, set_ie, clr_ie;
  logic [NUM_SRC-1:0] ip_v, ie_v, in_v;
  logic [CFG_W-1:0]   cfg_wdata;
  logic [CFG_W-1:0]   cfg_a [NUM_SRC];
  logic [PAD_W-1:0]   ip_pad, ie_pad, in_pad;
  logic [3:0]         region;
  logic [7:0]         ofs;

  irqgw_wdec #(.NUM_SRC(NUM_SRC), .HAS_CHILD(HAS_CHILD)) u_wdec (
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cfg_we_o    (cfg_we),
    .cfg_wdata_o (cfg_wdata),
    .set_ip_o    (set_ip),
    .clr_ip_o    (clr_ip),
    .set_ie_o    (set_ie),
    .clr_ie_o    (clr_ie)
  );

  assign cfg_a[0] = '0;
  assign ip_v[0]  = 1'b0;
  assign ie_v[0]  = 1'b0;
  assign in_v[0]  = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_cell
    irqgw_src_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .msi_mode_i  (msi_mode_i),
      .irq_i       (irq_i[i]),
      .cfg_we_i    (cfg_we[i]),
      .cfg_wdata_i (cfg_wdata),
      .set_ip_i    (set_ip[i]),
      .clr_ip_i    (clr_ip[i]),
      .set_ie_i    (set_ie[i]),
      .clr_ie_i    (clr_ie[i]),
      .dlv_clr_i   (dlv_clr_i[i]),
      .cfg_o       (cfg_a[i]),
      .ip_o        (ip_v[i]),
      .ie_o        (ie_v[i]),
      .in_o        (in_v[i])
    );
  end

  assign enpend_o = ip_v & ie_v;

  assign ip_pad = PAD_W'(ip_v);
  assign ie_pad = PAD_W'(ie_v);
  assign in_pad = PAD_W'(in_v);
  assign region = addr_i[11:8];
  assign ofs    = addr_i[7:0];

  always_comb begin
    rdata_o = '0;
    case (region)
      RG_CFG:
        for (int i = 0; i < NUM_SRC; i++)
          if (ofs == 8'(i)) rdata_o = {{(32-CFG_W){1'b0}}, cfg_a[i]};
      RG_SETIP:
        for (int w = 0; w < NWORDS; w++)
          if (ofs == 8'(w)) rdata_o = ip_pad[w*32 +: 32];
      RG_CLRIP:
        for (int w = 0; w < NWORDS; w++)
          if (ofs == 8'(w)) rdata_o = in_pad[w*32 +: 32];
      RG_SETIE:
        for (int w = 0; w < NWORDS; w++)
          if (ofs == 8'(w)) rdata_o = ie_pad[w*32 +: 32];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: tb/irq_gateway_array_tb_top.sv
`timescale 1ns/1ps
module irq_gateway_array_tb_top;
  localparam int NS = 20;
  localparam int NS_NC = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic msi_mode = 1'b0;
  logic [NS-1:0] irq = '0;
  logic [NS-1:0] dlv = '0;
  logic we = 1'b0, we_nc = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nc;
  logic [NS-1:0] enpend;
  logic [NS_NC-1:0] enpend_nc;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_gateway_array #(.NUM_SRC(NS), .HAS_CHILD(1'b1)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .msi_mode_i(msi_mode), .irq_i(irq),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .enpend_o(enpend), .dlv_clr_i(dlv));

  irq_gateway_array #(.NUM_SRC(NS_NC), .HAS_CHILD(1'b0)) dut_nc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .msi_mode_i(1'b0), .irq_i('0),
    .we_i(we_nc), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_nc),
    .enpend_o(enpend_nc), .dlv_clr_i('0));

  function automatic logic [11:0] ra(input int region, input int ofs);
    return {4'(region), 8'(ofs)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); addr = a; wdata = d; we = 1'b1;
    @(negedge clk_i); we = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i); addr = a; #1 d = rdata;
  endtask

  function automatic int sm_of(input int m);
    case (m)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h4;
      3: return 32'h5;
      4: return 32'h6;
      5: return 32'h7;
      default: return 32'h409;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R13 reset state
    rd(ra(1, 0), d); check("R13 pending", d, 0);
    rd(ra(3, 0), d); check("R13 enable", d, 0);
    rd(ra(2, 0), d); check("R13 input", d, 0);
    rd(ra(0, 5), d); check("R13 config", d, 0);
    check("R13 enpend", 32'(enpend), 0);

    // R1 / R2 configuration masking
    wr(ra(0, 3), 32'h0000_F3FE); rd(ra(0, 3), d); check("R1 mode kept", d, 32'h6);
    wr(ra(0, 3), 32'hFFFF_FFFF); rd(ra(0, 3), d); check("R2 delegated kept", d, 32'h7FF);
    @(negedge clk_i); addr = ra(0, 3); wdata = 32'h0000_0405; we_nc = 1'b1;
    @(negedge clk_i); we_nc = 1'b0; #1 check("R2 no child", rdata_nc, 0);
    wr(ra(0, 3), 0);

    // R4 rising edge
    wr(ra(0, 4), 32'h4);
    @(negedge clk_i); irq[4] = 1'b1;
    @(negedge clk_i);
    rd(ra(1, 0), d); check("R4 rise sets", d[4], 1);
    rd(ra(2, 0), d); check("R6 input high", d[4], 1);
    wr(ra(5, 1), 32'd4);
    repeat (2) @(negedge clk_i);
    rd(ra(1, 0), d); check("R4 steady high no retrigger", d[4], 0);
    irq[4] = 1'b0; repeat (2) @(negedge clk_i);
    rd(ra(1, 0), d); check("R4 fall ignored in rise mode", d[4], 0);

    // R4 falling edge
    irq[5] = 1'b1; @(negedge clk_i);
    wr(ra(0, 5), 32'h5);
    rd(ra(1, 0), d); check("R4 fall idle while high", d[5], 0);
    @(negedge clk_i); irq[5] = 1'b0; @(negedge clk_i);
    rd(ra(1, 0), d); check("R4 fall sets", d[5], 1);

    // R5 / R12 level high with delivery clear
    irq[6] = 1'b1;
    wr(ra(0, 6), 32'h6);
    rd(ra(1, 0), d); check("R5 level high sets", d[6], 1);
    wr(ra(5, 2), 32'd6);
    #1 check("R12 enpend", 32'(enpend[6]), 1);
    @(negedge clk_i); dlv[6] = 1'b1;
    @(negedge clk_i); dlv[6] = 1'b0; addr = ra(1, 0);
    #1 check("R12 dlv clear wins", rdata[6], 0);
    @(negedge clk_i); #1 check("R5 level re-asserts", rdata[6], 1);
    irq[6] = 1'b0;
    wr(ra(0, 6), 0);

    // R5 level low
    irq[7] = 1'b1; wr(ra(0, 7), 32'h7);
    rd(ra(1, 0), d); check("R5 level low idle while high", d[7], 0);
    irq[7] = 1'b0; repeat (2) @(negedge clk_i);
    rd(ra(1, 0), d); check("R5 level low sets", d[7], 1);
    irq[7] = 1'b1; wr(ra(0, 7), 0);

    // R6 raw input in off mode
    irq[11] = 1'b1; repeat (2) @(negedge clk_i);
    rd(ra(2, 0), d); check("R6 input off mode", d[11], 1);
    rd(ra(1, 0), d); check("R6 off mode no pending", d[11], 0);
    irq[11] = 1'b0;

    // R7 / R8 software rule sweep on source 9
    for (int m = 0; m < 7; m++) begin
      for (int msi = 0; msi < 2; msi++) begin
        bit frz, lvl, e_set;
        frz = (m == 0) || (m == 6);
        lvl = (m == 4) || (m == 5);
        e_set = !frz && (!lvl || (msi == 1));
        msi_mode = (msi == 1);
        irq[9] = (m == 5);
        wr(ra(0, 9), 0);
        wr(ra(0, 9), 32'(sm_of(m)));
        wr(ra(5, 0), 32'd9);
        rd(ra(1, 0), d); check(lvl ? "R8 set pending" : "R7 set pending", d[9], e_set);
        wr(ra(2, 0), 32'h200);
        rd(ra(1, 0), d); check(lvl ? "R8 clear pending" : "R7 clear pending", d[9], e_set && lvl);
        wr(ra(5, 2), 32'd9);
        rd(ra(3, 0), d); check("R7 set enable", d[9], !frz);
        wr(ra(5, 3), 32'd9);
        rd(ra(3, 0), d); check("R7 clear enable", d[9], 0);
        wr(ra(0, 9), 0);
      end
    end
    msi_mode = 1'b0; irq = '0;

    // R9 / R10 boundaries and read-zero regions
    for (int i = 1; i < NS; i++) wr(ra(0, i), 32'h1);
    wr(ra(1, 0), 32'hFFFF_FFFF);
    exp_w = (32'h1 << NS) - 32'h2;
    rd(ra(1, 0), d); check("R9 set pending bitmap", d, exp_w);
    wr(ra(3, 0), 32'hFFFF_FFFF);
    rd(ra(3, 0), d); check("R10 enable bitmap", d, exp_w);
    check("R12 enpend all", 32'(enpend), exp_w);
    rd(ra(4, 0), d); check("R10 clear-enable reads 0", d, 0);
    for (int o = 0; o < 5; o++) begin
      rd(ra(5, o), d); check("R10 by-number reads 0", d, 0);
    end
    wr(ra(2, 0), 32'hFFFF_FFFF);
    rd(ra(1, 0), d); check("R9 clear pending bitmap", d, 0);
    wr(ra(5, 0), 32'd0); wr(ra(5, 0), 32'(NS)); wr(ra(5, 0), 32'd31);
    rd(ra(1, 0), d); check("R9 out-of-range numbers", d, 0);
    wr(ra(0, 0), 32'h1); wr(ra(0, NS + 2), 32'h1);
    rd(ra(0, 0), d); check("R9 id0 config", d, 0);
    rd(ra(0, NS + 2), d); check("R10 missing id config", d, 0);

    // R11 byte-swapped number
    wr(ra(5, 0), 32'h0D00_0000);
    rd(ra(1, 0), d); check("R11 plain big value ignored", d, 0);
    wr(ra(5, 4), 32'h0D00_0000);
    rd(ra(1, 0), d); check("R11 swapped sets 13", d, 32'h2000);

    // R3 config write clears state
    wr(ra(5, 0), 32'd12);
    wr(ra(0, 13), 0);
    rd(ra(1, 0), d); check("R3 zero cfg pending", d[13], 0);
    rd(ra(3, 0), d); check("R3 zero cfg enable", d[13], 0);
    wr(ra(0, 12), 32'h405);
    rd(ra(1, 0), d); check("R3 delegated pending", d[12], 0);
    rd(ra(3, 0), d); check("R3 delegated enable", d[12], 0);
    rd(ra(0, 12), d); check("R2 child index", d, 32'h405);
    rd(ra(3, 0), d); check("R3 others keep enable", d[14], 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule